// File: doc/BRIEF.md
# Control/Status Register Instruction Executor

This block carries out the six register-access instructions of a 64-bit integer core that operate on control and status registers. Each cycle it may be handed one 32-bit instruction word, together with the address of that instruction and the contents of the source integer register. It decodes the word and chooses between an atomic swap, a bit-set and a bit-clear, each in a register-sourced or immediate-sourced form. It then performs the access against a small local bank of status registers. The results appear on a status-register access port (address, read strobe, old value, write strobe, new value), on an integer writeback port (destination index, enable, data) and as the address of the following instruction.

Each variant has its own rules for which side effects happen. A swap whose destination is x0 issues no read. A set or clear whose source index or immediate is zero issues no write. The old value is never written back to x0. Everything is decided in a single cycle: the outputs are combinational in the current inputs and bank contents, and the bank takes the new value on the next rising clock edge. A word that is not one of the six instructions, or that names a status register the bank does not hold, raises an illegal flag and causes no side effect at all.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction is accepted only when bits 6:0 equal 7'h73 and bits 13:12 are nonzero. Bit 14 set selects the immediate form. Bits 13:12 select the operation: 1 is swap, 2 is set, 3 is clear. The destination index is bits 11:7, the source index or immediate is bits 19:15 and the status register address is bits 31:20. Any other valid word raises `illegal` and asserts no strobe.
- R2: A recognized instruction whose address lies outside CSR_BASE to CSR_BASE+NUM_CSR-1 raises `illegal`, asserts no strobe and leaves the bank unchanged.
- R3: The register swap writes `rs1_val` to the addressed register. It issues a read, and a writeback of the old value, only when the destination index is nonzero.
- R4: The register set and clear always read. They write old|rs1_val and old&~rs1_val respectively, and only when the source index is nonzero.
- R5: The immediate forms use bits 19:15 zero-extended to XLEN in place of `rs1_val`. The immediate set and clear always read, and write only when the immediate is nonzero.
- R6: The immediate swap always reads and always writes the zero-extended immediate, whatever the destination index.
- R7: `rd_wr_en` is high only when a read is performed and the destination index is nonzero. `rd_data` then carries the value the register held before this instruction.
- R8: `next_pc` equals `pc` + 4.
- R9: A write takes effect at the rising clock edge that ends the instruction's cycle. An instruction in a later cycle reads the new value.
- R10: Synchronous active-low reset clears every bank register to zero. While `instr_valid` is low, no strobe and no `illegal` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| rs1_val | input | XLEN | Contents of the source integer register |
| next_pc | output | XLEN | Address of the following instruction |
| csr_addr | output | 12 | Status register address |
| csr_rd_en | output | 1 | A read of the status register is performed |
| csr_rd_data | output | XLEN | Old register value (zero when no read) |
| csr_wr_en | output | 1 | A write of the status register is performed |
| csr_wr_data | output | XLEN | New register value (zero when no write) |
| rd_addr | output | 5 | Destination integer register index |
| rd_wr_en | output | 1 | Integer writeback enable |
| rd_data | output | XLEN | Integer writeback data |
| illegal | output | 1 | Word not executable by this block |

## Verification
The bench sweeps all eight values of bits 14:12 across every bank address plus one address outside the bank. Each case runs with destination x0 and a nonzero destination, and with source field values 0, 3 and 31. The zero source field tells apart the forms that suppress their write from the swaps that do not. Destination x0 tells the suppressed swap read apart from the immediate swap that still reads. The two reserved encodings and the outside address show that illegal words have no side effect. Each register is loaded with a distinct preset before each case and read back afterwards. This shows that the old value reaches the writeback and that set, clear and swap leave the register with the right contents.

// File: rtl/csr_exec_pkg.sv
// Shared types for the status-register instruction executor.
// Assumes the standard system opcode and the 32-bit base instruction layout.
package csr_exec_pkg;

    localparam logic [6:0] SYSTEM_OPCODE = 7'h73;

    // Operation kind taken directly from bits 13:12 of the word.
    typedef enum logic [1:0] {
        CSR_OP_NONE = 2'b00,
        CSR_OP_SWAP = 2'b01,
        CSR_OP_SET  = 2'b10,
        CSR_OP_CLR  = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic        match;    // opcode and operation are recognized
        csr_op_e     op;
        logic        use_imm;  // bit 14: immediate source form
        logic [4:0]  rd;
        logic [4:0]  src_idx;  // source index or immediate
        logic [11:0] addr;
    } csr_dec_t;

endpackage

// File: rtl/csr_decoder.sv
// Splits an instruction word into the fields the executor needs.
// Assumes: purely combinational; validity gating is done by the caller.
module csr_decoder
    import csr_exec_pkg::*;
(
    input  logic [31:0] instr,
    output csr_dec_t    dec
);

    // Field extraction and pattern match.
    always_comb begin
        dec.op      = csr_op_e'(instr[13:12]);
        dec.use_imm = instr[14];
        dec.rd      = instr[11:7];
        dec.src_idx = instr[19:15];
        dec.addr    = instr[31:20];
        dec.match   = (instr[6:0] == SYSTEM_OPCODE) && (instr[13:12] != 2'b00);
    end

endmodule

// File: rtl/csr_alu.sv
// Computes the value to store for swap, set and clear.
// Assumes the caller decides whether the write actually happens.
module csr_alu
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  csr_op_e           op,
    input  logic [XLEN-1:0]   old_val,
    input  logic [XLEN-1:0]   src_val,
    output logic [XLEN-1:0]   new_val
);

    // Select the update rule for the operation kind.
    always_comb begin
        unique case (op)
            CSR_OP_SWAP: new_val = src_val;
            CSR_OP_SET:  new_val = old_val | src_val;
            CSR_OP_CLR:  new_val = old_val & ~src_val;
            default:     new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_bank.sv
// Small bank of status registers at consecutive addresses from CSR_BASE.
// Assumes: one read and one write per cycle to the same address; the read
// returns the value held before any write of this cycle.
module csr_bank #(
    parameter int              XLEN     = 64,
    parameter int              NUM_CSR  = 4,
    parameter logic [11:0]     CSR_BASE = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       addr,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wdata,
    output logic              hit,
    output logic [XLEN-1:0]   rdata
);

    localparam int          IDX_W = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;
    localparam logic [12:0] LIMIT = 13'(NUM_CSR);

    logic [12:0]       offset;
    logic [IDX_W-1:0]  idx;
    logic [XLEN-1:0]   regs [NUM_CSR];

    // Address to bank index translation and range check.
    always_comb begin
        offset = {1'b0, addr} - {1'b0, CSR_BASE};
        hit    = !offset[12] && (offset < LIMIT);
        idx    = offset[IDX_W-1:0];
    end

    // Read multiplexer over the implemented registers.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (hit && (idx == IDX_W'(i))) rdata = regs[i];
        end
    end

    // One storage register per implemented address.
    for (genvar g = 0; g < NUM_CSR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                                   regs[g] <= '0;
            else if (wr_en && hit && (idx == IDX_W'(g)))  regs[g] <= wdata;
        end
    end

endmodule

// File: rtl/csr_exec_unit.sv
// Executes one status-register instruction per cycle against a local bank.
// Assumes privilege checks and traps are handled elsewhere; outputs are
// combinational and the bank updates at the next rising edge.
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          NUM_CSR  = 4,
    parameter logic [11:0] CSR_BASE = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs1_val,
    output logic [XLEN-1:0]   next_pc,
    output logic [11:0]       csr_addr,
    output logic              csr_rd_en,
    output logic [XLEN-1:0]   csr_rd_data,
    output logic              csr_wr_en,
    output logic [XLEN-1:0]   csr_wr_data,
    output logic [4:0]        rd_addr,
    output logic              rd_wr_en,
    output logic [XLEN-1:0]   rd_data,
    output logic              illegal
);

    localparam int IMM_PAD = XLEN - 5;

    csr_dec_t        dec;
    logic            bank_hit;
    logic [XLEN-1:0] bank_rdata;
    logic [XLEN-1:0] src_val;
    logic [XLEN-1:0] new_val;
    logic            legal;
    logic            do_read;
    logic            do_write;

    csr_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Source operand: register value or zero-extended immediate.
    always_comb begin
        src_val = dec.use_imm ? {{IMM_PAD{1'b0}}, dec.src_idx} : rs1_val;
    end

    csr_alu #(.XLEN(XLEN)) u_alu (
        .op      (dec.op),
        .old_val (bank_rdata),
        .src_val (src_val),
        .new_val (new_val)
    );

    csr_bank #(.XLEN(XLEN), .NUM_CSR(NUM_CSR), .CSR_BASE(CSR_BASE)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (dec.addr),
        .wr_en (do_write),
        .wdata (new_val),
        .hit   (bank_hit),
        .rdata (bank_rdata)
    );

    // Per-variant side-effect control.
    always_comb begin
        legal    = instr_valid && dec.match && bank_hit;
        do_read  = legal && !((dec.op == CSR_OP_SWAP) && !dec.use_imm && (dec.rd == 5'd0));
        do_write = legal && ((dec.op == CSR_OP_SWAP) || (dec.src_idx != 5'd0));
    end

    // Port outputs.
    always_comb begin
        next_pc     = pc + XLEN'(4);
        csr_addr    = dec.addr;
        csr_rd_en   = do_read;
        csr_rd_data = do_read ? bank_rdata : '0;
        csr_wr_en   = do_write;
        csr_wr_data = do_write ? new_val : '0;
        rd_addr     = dec.rd;
        rd_wr_en    = do_read && (dec.rd != 5'd0);
        rd_data     = rd_wr_en ? bank_rdata : '0;
        illegal     = instr_valid && !legal;
    end

endmodule

// File: rtl/csr_exec_checker.sv
// Protocol checks for the executor, attached by bind.
// Assumes the ports of csr_exec_unit; observes only, drives nothing.
module csr_exec_checker #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [31:0]       instr,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   next_pc,
    input logic [11:0]       csr_addr,
    input logic              csr_rd_en,
    input logic [XLEN-1:0]   csr_rd_data,
    input logic              csr_wr_en,
    input logic [XLEN-1:0]   csr_wr_data,
    input logic [4:0]        rd_addr,
    input logic              rd_wr_en,
    input logic [XLEN-1:0]   rd_data,
    input logic              illegal
);

    assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!csr_rd_en && !csr_wr_en && !rd_wr_en));

    assert_swap_x0_noread_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[14:12] == 3'b001 && instr[11:7] == 5'd0) |-> !csr_rd_en);

    assert_set_keeps_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && instr[13:12] == 2'b10) |-> ((csr_wr_data & csr_rd_data) == csr_rd_data));

    assert_clear_no_new_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && instr[13:12] == 2'b11) |-> ((csr_wr_data & ~csr_rd_data) == '0));

    assert_imm_zero_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && instr[14] && instr[13:12] != 2'b01) |-> (instr[19:15] != 5'd0));

    assert_writeback_rules_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wr_en |-> (rd_addr != 5'd0 && csr_rd_en && rd_data == csr_rd_data));

    assert_next_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (next_pc == pc + XLEN'(4)));

    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(csr_wr_en) && csr_rd_en && csr_addr == $past(csr_addr))
        |-> (csr_rd_data == $past(csr_wr_data)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!illegal && !csr_rd_en && !csr_wr_en && !rd_wr_en));

endmodule

bind csr_exec_unit csr_exec_checker #(.XLEN(XLEN)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pc          (pc),
    .next_pc     (next_pc),
    .csr_addr    (csr_addr),
    .csr_rd_en   (csr_rd_en),
    .csr_rd_data (csr_rd_data),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_data (csr_wr_data),
    .rd_addr     (rd_addr),
    .rd_wr_en    (rd_wr_en),
    .rd_data     (rd_data),
    .illegal     (illegal)
);

// File: tb/tb_csr_exec_unit.sv
// Sweep bench for csr_exec_unit with a reference model of the bank.
module tb_csr_exec_unit;

    localparam int          XLEN = 64;
    localparam int          NCSR = 4;
    localparam logic [11:0] BASE = 12'h340;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            instr_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] pc = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic [XLEN-1:0] next_pc, csr_rd_data, csr_wr_data, rd_data;
    logic [11:0]     csr_addr;
    logic            csr_rd_en, csr_wr_en, rd_wr_en, illegal;
    logic [4:0]      rd_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [XLEN-1:0] model [NCSR];

    always #10 clk = ~clk;

    csr_exec_unit #(.XLEN(XLEN), .NUM_CSR(NCSR), .CSR_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc(pc), .rs1_val(rs1_val), .next_pc(next_pc), .csr_addr(csr_addr),
        .csr_rd_en(csr_rd_en), .csr_rd_data(csr_rd_data), .csr_wr_en(csr_wr_en),
        .csr_wr_data(csr_wr_data), .rd_addr(rd_addr), .rd_wr_en(rd_wr_en),
        .rd_data(rd_data), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one word at the falling edge; outputs settle before the rising edge.
    task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input logic [11:0] a,
                         input logic [4:0] rd, input logic [4:0] fld, input logic [XLEN-1:0] r1);
        @(negedge clk);
        instr_valid = 1'b1;
        instr       = {a, fld, f3, rd, opc};
        rs1_val     = r1;
        pc          = pc + 64'h40;
        #2;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    // Read back a bank register with a register-set, source x0 (no write).
    task automatic readback(input int ai, input string tag);
        issue(7'h73, 3'b010, BASE + 12'(ai), 5'd1, 5'd0, '1);
        chk({tag, " readback data"}, rd_data, model[ai]);
        chk({tag, " readback no write"}, XLEN'(csr_wr_en), '0);
        step();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0]      fields [3];
        logic [XLEN-1:0] pre, r1, src, old, nv;
        logic [11:0]     a;
        logic [4:0]      rd;
        bit              legal, rden, wren;
        fields[0] = 5'd0; fields[1] = 5'd3; fields[2] = 5'd31;
        for (int i = 0; i < NCSR; i++) model[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: idle, no strobes; reset contents are zero.
        @(negedge clk); #2;
        chk("R10 idle illegal", XLEN'(illegal), '0);
        chk("R10 idle strobes", XLEN'({csr_rd_en, csr_wr_en, rd_wr_en}), '0);
        for (int i = 0; i < NCSR; i++) readback(i, "R10 reset");

        // R1: wrong opcode is illegal with no side effect.
        issue(7'h33, 3'b001, BASE, 5'd4, 5'd7, 64'hDEAD);
        chk("R1 bad opcode illegal", XLEN'(illegal), 1);
        chk("R1 bad opcode strobes", XLEN'({csr_rd_en, csr_wr_en, rd_wr_en}), '0);
        step();
        readback(0, "R1 bad opcode");

        for (int f3 = 0; f3 < 8; f3++) begin
            for (int ai = 0; ai <= NCSR; ai++) begin
                for (int rs = 0; rs < 2; rs++) begin
                    for (int fi = 0; fi < 3; fi++) begin
                        a   = BASE + 12'(ai);
                        rd  = (rs != 0) ? 5'd5 : 5'd0;
                        pre = 64'h0123_4567_89AB_CDEF + 64'(f3 * 97 + ai * 13 + fi * 7 + rs) * 64'h0101_0101_0101_0101;
                        r1  = ~pre ^ 64'h00FF_00FF_0000_FFFF;
                        if (ai < NCSR) begin
                            issue(7'h73, 3'b001, a, 5'd1, 5'd2, pre);
                            step();
                            model[ai] = pre;
                        end
                        legal = (f3[1:0] != 2'b00) && (ai < NCSR);
                        src   = f3[2] ? XLEN'(fields[fi]) : r1;
                        old   = (ai < NCSR) ? model[ai] : '0;
                        rden  = legal && !(f3 == 1 && rd == 5'd0);
                        wren  = legal && (f3[1:0] == 2'b01 || fields[fi] != 5'd0);
                        case (f3[1:0])
                            2'b01:   nv = src;
                            2'b10:   nv = old | src;
                            default: nv = old & ~src;
                        endcase
                        issue(7'h73, 3'(f3), a, rd, fields[fi], r1);
                        chk("R1/R2 illegal flag", XLEN'(illegal), XLEN'(!legal));
                        chk("R3/R4/R5/R6 read strobe", XLEN'(csr_rd_en), XLEN'(rden));
                        chk("R3/R4/R5/R6 write strobe", XLEN'(csr_wr_en), XLEN'(wren));
                        if (wren) chk("R4/R5/R6 write data", csr_wr_data, nv);
                        chk("R7 writeback enable", XLEN'(rd_wr_en), XLEN'(rden && rd != 5'd0));
                        if (rden && rd != 5'd0) chk("R7 old value", rd_data, old);
                        chk("R8 next pc", next_pc, pc + 64'd4);
                        step();
                        if (wren) model[ai] = nv;
                        if (ai < NCSR) readback(ai, "R9 stored value");
                    end
                end
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule